// File: doc/BRIEF.md
# SMBus Host Transaction Sequencer

This block turns one SMBus host transaction into the ordered series of byte-level bus operations that a lower byte engine carries out. The operations are start, repeated start, byte write, byte read with a chosen acknowledge, and stop. A request carries a type code, a 7-bit target address, a command byte, a write byte count and up to `MAX_BLK` write bytes. The sequencer builds the phase list for that type. This covers repeated starts, low-then-high word order, block counts and optional packet error checking. It hands the engine one operation at a time.

Read data leaves as an indexed byte stream. When the transaction ends, a one-cycle done pulse arrives with a status code and the number of data bytes read. The sequencer handles target not-acknowledge, illegal block counts and checksum mismatches itself. In each of these cases it ends the transaction with a stop and returns the matching status.

Top module: `smb_txn_seq`

## Requirements
- R1: Type codes are 0 quick, 1 send byte, 2 receive byte, 3 write byte, 4 read byte, 5 write word, 6 read word, 7 process call, 8 block write, 9 block read, 10 block process call. Every transaction opens with a start and closes with a stop. The first address byte is {addr, 0}, except for receive byte, which uses {addr, 1}.
- R2: Quick sends {addr, wdata bit 0} as its only byte and then a stop. Quick never carries a checksum byte.
- R3: Read byte, read word, process call, block read and block process call first write the address and the command. They then issue a repeated start and write {addr, 1}.
- R4: Word data goes low byte first in both directions. For writes the low byte is wdata byte 0. For reads the low byte is read index 0.
- R5: Every read byte is acknowledged except the last one before stop, which is answered with not-acknowledge. When checksums are on, the checksum byte is that last byte.
- R6: In block reads the first read byte is the count, and exactly that many data bytes follow. The count limit is 32 for block read and 31 for block process call. count_o reports the number of data bytes read.
- R7: Block writes send the count byte right after the command, then that many bytes. A request with a write count of 0, or above 32 (31 for block process call), ends with status 2 and no bus operation.
- R8: With pec_en_i set, write-ending transactions send one CRC-8 byte just before the stop. The CRC uses polynomial 0x07 and initial value 0, computed MSB first over every byte on the bus, including address bytes.
- R9: With pec_en_i set, read-ending transactions read one more byte and compare it with the CRC. A mismatch gives status 3.
- R10: A not-acknowledge on any byte the host writes is followed by an immediate stop and status 1.
- R11: A device count of 0 or above the limit is followed by a stop and status 2, with no data byte read.
- R12: Type codes 11 to 15 give status 2 and a done pulse in the cycle after the request, with no bus operation.
- R13: done_o pulses for one cycle in the cycle after the engine completes the stop. busy_o is high from accept until that point, and requests made while busy are ignored.
- R14: The engine operation is held stable with eng_valid_o high until eng_done_i. Operation codes are 0 start, 1 repeated start, 2 write, 3 read, 4 stop. eng_ack_o=1 means the host acknowledges the read byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Transaction request, taken when idle |
| type_i | input | 4 | Transaction type code |
| addr_i | input | 7 | Target address |
| cmd_i | input | 8 | Command byte |
| wcount_i | input | 6 | Block write byte count |
| wdata_i | input | 256 | Write bytes, byte i at bits 8i+7..8i |
| pec_en_i | input | 1 | Enable checksum byte |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle completion pulse |
| status_o | output | 2 | 0 ok, 1 nack, 2 protocol, 3 checksum |
| rd_valid_o | output | 1 | Read data byte strobe |
| rd_idx_o | output | 6 | Index of the read byte |
| rd_data_o | output | 8 | Read data byte |
| count_o | output | 6 | Data bytes read in this transaction |
| eng_valid_o | output | 1 | Engine operation presented |
| eng_op_o | output | 3 | Engine operation code |
| eng_wdata_o | output | 8 | Byte to write |
| eng_ack_o | output | 1 | Acknowledge choice for a read |
| eng_done_i | input | 1 | Engine finished the presented operation |
| eng_rdata_i | input | 8 | Byte read by the engine |
| eng_nack_i | input | 1 | Target did not acknowledge the written byte |

## Verification
Two events can land on the same engine response. One is the advance of a write phase, meaning the byte counter or the next phase. The other is a target not-acknowledge on that byte. The bench injects not-acknowledges at chosen write positions, including the address, the count byte and the checksum byte, and expects the abort to win: a stop comes next and the status is 1. A second overlap is a fresh request that arrives while a block write is still running. The bench judges it by the unchanged operation transcript, and by busy_o and the operation log staying quiet after the done pulse.

// File: rtl/smb_seq_pkg.sv
package smb_seq_pkg;
  typedef enum logic [2:0] {
    OP_START = 3'd0, OP_RSTART = 3'd1, OP_WRITE = 3'd2, OP_READ = 3'd3, OP_STOP = 3'd4
  } bus_op_e;

  typedef enum logic [3:0] {
    T_QUICK = 4'd0, T_SEND = 4'd1, T_RECV = 4'd2, T_WRB = 4'd3, T_RDB = 4'd4,
    T_WRW = 4'd5, T_RDW = 4'd6, T_PCALL = 4'd7, T_BLKW = 4'd8, T_BLKR = 4'd9,
    T_BPCALL = 4'd10
  } txn_e;

  typedef enum logic [1:0] {
    ST_OK = 2'd0, ST_NACK = 2'd1, ST_PROTO = 2'd2, ST_PEC = 2'd3
  } status_e;

  typedef enum logic [3:0] {
    PH_IDLE, PH_START, PH_ADDRW, PH_CMD, PH_WCNT, PH_WDATA, PH_RSTART,
    PH_ADDRR, PH_RCNT, PH_RDATA, PH_PECW, PH_PECR, PH_STOP
  } phase_e;

  typedef struct packed {
    logic       quick;
    logic       addr_rd;
    logic       has_cmd;
    logic       wr_blk;
    logic [1:0] wr_fix;
    logic       has_rs;
    logic       rd_blk;
    logic [1:0] rd_fix;
  } plan_t;
endpackage

// File: rtl/smb_plan_decode.sv
module smb_plan_decode
  import smb_seq_pkg::*;
(
  input  logic [3:0] type_i,
  output plan_t      plan_o,
  output logic       legal_o,
  output logic       short_o
);
  always_comb begin
    plan_o  = '0;
    legal_o = 1'b1;
    short_o = 1'b0;
    case (type_i)
      T_QUICK:  plan_o.quick = 1'b1;
      T_SEND:   plan_o.wr_fix = 2'd1;
      T_RECV:   begin plan_o.addr_rd = 1'b1; plan_o.rd_fix = 2'd1; end
      T_WRB:    begin plan_o.has_cmd = 1'b1; plan_o.wr_fix = 2'd1; end
      T_RDB:    begin plan_o.has_cmd = 1'b1; plan_o.has_rs = 1'b1; plan_o.rd_fix = 2'd1; end
      T_WRW:    begin plan_o.has_cmd = 1'b1; plan_o.wr_fix = 2'd2; end
      T_RDW:    begin plan_o.has_cmd = 1'b1; plan_o.has_rs = 1'b1; plan_o.rd_fix = 2'd2; end
      T_PCALL:  begin
        plan_o.has_cmd = 1'b1; plan_o.wr_fix = 2'd2;
        plan_o.has_rs  = 1'b1; plan_o.rd_fix = 2'd2;
      end
      T_BLKW:   begin plan_o.has_cmd = 1'b1; plan_o.wr_blk = 1'b1; end
      T_BLKR:   begin plan_o.has_cmd = 1'b1; plan_o.has_rs = 1'b1; plan_o.rd_blk = 1'b1; end
      T_BPCALL: begin
        plan_o.has_cmd = 1'b1; plan_o.wr_blk = 1'b1;
        plan_o.has_rs  = 1'b1; plan_o.rd_blk = 1'b1;
        short_o = 1'b1;
      end
      default:  legal_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/smb_crc8_step.sv
module smb_crc8_step #(
  parameter logic [7:0] POLY = 8'h07
) (
  input  logic [7:0] crc_i,
  input  logic [7:0] byte_i,
  output logic [7:0] crc_o
);
  always_comb begin
    crc_o = crc_i ^ byte_i;
    for (int b = 0; b < 8; b++) begin
      crc_o = crc_o[7] ? ((crc_o << 1) ^ POLY) : (crc_o << 1);
    end
  end
endmodule

// File: rtl/smb_txn_seq.sv
module smb_txn_seq
  import smb_seq_pkg::*;
#(
  parameter  int unsigned MAX_BLK = 32,
  localparam int unsigned CW      = $clog2(MAX_BLK + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_i,
  input  logic [3:0]           type_i,
  input  logic [6:0]           addr_i,
  input  logic [7:0]           cmd_i,
  input  logic [CW-1:0]        wcount_i,
  input  logic [8*MAX_BLK-1:0] wdata_i,
  input  logic                 pec_en_i,
  output logic                 busy_o,
  output logic                 done_o,
  output logic [1:0]           status_o,
  output logic                 rd_valid_o,
  output logic [CW-1:0]        rd_idx_o,
  output logic [7:0]           rd_data_o,
  output logic [CW-1:0]        count_o,
  output logic                 eng_valid_o,
  output logic [2:0]           eng_op_o,
  output logic [7:0]           eng_wdata_o,
  output logic                 eng_ack_o,
  input  logic                 eng_done_i,
  input  logic [7:0]           eng_rdata_i,
  input  logic                 eng_nack_i
);
  phase_e               phase_q, ph_wr, end_w;
  plan_t                plan_q, plan_d;
  logic                 legal_d, short_d, bad_req, crc_upd, rd_phase;
  logic [6:0]           addr_q;
  logic [7:0]           cmd_q, crc_q, crc_nx, crc_in, rd_data_q;
  logic [8*MAX_BLK-1:0] wbuf_q;
  logic [CW-1:0]        wcnt_q, lim_q, lim_d, left_q, widx_q, ridx_q, rd_idx_q;
  logic                 pec_q, done_q, rd_valid_q;
  status_e              status_q;

  smb_plan_decode u_dec (.type_i(type_i), .plan_o(plan_d), .legal_o(legal_d), .short_o(short_d));

  assign lim_d   = short_d ? CW'(MAX_BLK - 1) : CW'(MAX_BLK);
  assign bad_req = !legal_d || (plan_d.wr_blk && (wcount_i == '0 || wcount_i > lim_d));

  // byte operation presented to the engine
  always_comb begin
    eng_op_o    = OP_STOP;
    eng_wdata_o = '0;
    eng_ack_o   = 1'b0;
    unique case (phase_q)
      PH_START:  eng_op_o = OP_START;
      PH_ADDRW:  begin
        eng_op_o    = OP_WRITE;
        eng_wdata_o = {addr_q, plan_q.quick ? wbuf_q[0] : plan_q.addr_rd};
      end
      PH_CMD:    begin eng_op_o = OP_WRITE; eng_wdata_o = cmd_q; end
      PH_WCNT:   begin eng_op_o = OP_WRITE; eng_wdata_o = 8'(wcnt_q); end
      PH_WDATA:  begin eng_op_o = OP_WRITE; eng_wdata_o = wbuf_q[{widx_q, 3'b000} +: 8]; end
      PH_RSTART: eng_op_o = OP_RSTART;
      PH_ADDRR:  begin eng_op_o = OP_WRITE; eng_wdata_o = {addr_q, 1'b1}; end
      PH_RCNT:   begin eng_op_o = OP_READ; eng_ack_o = 1'b1; end
      PH_RDATA:  begin eng_op_o = OP_READ; eng_ack_o = (left_q != CW'(1)) || pec_q; end
      PH_PECW:   begin eng_op_o = OP_WRITE; eng_wdata_o = crc_q; end
      PH_PECR:   eng_op_o = OP_READ;
      default:   eng_op_o = OP_STOP;
    endcase
  end

  assign eng_valid_o = phase_q != PH_IDLE;
  assign busy_o      = phase_q != PH_IDLE;
  assign rd_phase    = phase_q inside {PH_RCNT, PH_RDATA};
  assign crc_upd     = phase_q inside {PH_ADDRW, PH_CMD, PH_WCNT, PH_WDATA, PH_ADDRR, PH_RCNT, PH_RDATA};
  assign crc_in      = rd_phase ? eng_rdata_i : eng_wdata_o;

  smb_crc8_step #(.POLY(8'h07)) u_crc (.crc_i(crc_q), .byte_i(crc_in), .crc_o(crc_nx));

  always_comb begin
    end_w = pec_q ? PH_PECW : PH_STOP;
    if (plan_q.wr_blk)           ph_wr = PH_WCNT;
    else if (plan_q.wr_fix != 0) ph_wr = PH_WDATA;
    else if (plan_q.has_rs)      ph_wr = PH_RSTART;
    else                         ph_wr = end_w;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q  <= PH_IDLE;   plan_q     <= '0;  addr_q    <= '0;  cmd_q    <= '0;
      wbuf_q   <= '0;        wcnt_q     <= '0;  lim_q     <= '0;  left_q   <= '0;
      widx_q   <= '0;        ridx_q     <= '0;  rd_idx_q  <= '0;  crc_q    <= '0;
      pec_q    <= 1'b0;      done_q     <= 1'b0; rd_valid_q <= 1'b0; rd_data_q <= '0;
      status_q <= ST_OK;
    end else begin
      done_q     <= 1'b0;
      rd_valid_q <= 1'b0;
      if (phase_q == PH_IDLE) begin
        if (req_i) begin
          plan_q <= plan_d;  addr_q <= addr_i;  cmd_q <= cmd_i;  wbuf_q <= wdata_i;
          wcnt_q <= wcount_i; lim_q <= lim_d;   pec_q <= pec_en_i;
          widx_q <= '0;  ridx_q <= '0;  crc_q <= '0;  status_q <= ST_OK;
          if (bad_req) begin
            status_q <= ST_PROTO;
            done_q   <= 1'b1;
          end else begin
            phase_q <= PH_START;
          end
        end
      end else if (eng_done_i) begin
        if (crc_upd) crc_q <= crc_nx;
        if (eng_op_o == OP_WRITE && eng_nack_i) begin
          status_q <= ST_NACK;
          phase_q  <= PH_STOP;
        end else begin
          unique case (phase_q)
            PH_START: phase_q <= PH_ADDRW;
            PH_ADDRW: begin
              if (plan_q.quick)        phase_q <= PH_STOP;
              else if (plan_q.addr_rd) begin phase_q <= PH_RDATA; left_q <= CW'(plan_q.rd_fix); end
              else if (plan_q.has_cmd) phase_q <= PH_CMD;
              else begin phase_q <= ph_wr; left_q <= CW'(plan_q.wr_fix); end
            end
            PH_CMD:   begin phase_q <= ph_wr; left_q <= CW'(plan_q.wr_fix); end
            PH_WCNT:  begin phase_q <= PH_WDATA; left_q <= wcnt_q; end
            PH_WDATA: begin
              widx_q <= widx_q + 1'b1;
              if (left_q == CW'(1)) phase_q <= plan_q.has_rs ? PH_RSTART : end_w;
              else                  left_q  <= left_q - 1'b1;
            end
            PH_RSTART: phase_q <= PH_ADDRR;
            PH_ADDRR: begin
              if (plan_q.rd_blk) phase_q <= PH_RCNT;
              else begin phase_q <= PH_RDATA; left_q <= CW'(plan_q.rd_fix); end
            end
            PH_RCNT: begin
              if (eng_rdata_i == 8'd0 || eng_rdata_i > 8'(lim_q)) begin
                status_q <= ST_PROTO;
                phase_q  <= PH_STOP;
              end else begin
                phase_q <= PH_RDATA;
                left_q  <= CW'(eng_rdata_i);
              end
            end
            PH_RDATA: begin
              rd_valid_q <= 1'b1;
              rd_data_q  <= eng_rdata_i;
              rd_idx_q   <= ridx_q;
              ridx_q     <= ridx_q + 1'b1;
              if (left_q == CW'(1)) phase_q <= pec_q ? PH_PECR : PH_STOP;
              else                  left_q  <= left_q - 1'b1;
            end
            PH_PECW: phase_q <= PH_STOP;
            PH_PECR: begin
              if (eng_rdata_i != crc_q) status_q <= ST_PEC;
              phase_q <= PH_STOP;
            end
            default: begin
              phase_q <= PH_IDLE;
              done_q  <= 1'b1;
            end
          endcase
        end
      end
    end
  end

  assign done_o     = done_q;
  assign status_o   = status_q;
  assign rd_valid_o = rd_valid_q;
  assign rd_idx_o   = rd_idx_q;
  assign rd_data_o  = rd_data_q;
  assign count_o    = ridx_q;

  // R14: presented operation held until the engine completes it
  p_op_hold_r14: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_valid_o && !eng_done_i |=> eng_valid_o && $stable(eng_op_o) && $stable(eng_wdata_o) && $stable(eng_ack_o));

  // R10: target refusal on a written byte leads straight to stop
  p_nack_stop_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_valid_o && eng_done_i && eng_op_o == 3'(OP_WRITE) && eng_nack_i |=> eng_valid_o && eng_op_o == 3'(OP_STOP));

  // R13: completed stop gives done and idle next cycle
  p_done_after_stop_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_valid_o && eng_done_i && eng_op_o == 3'(OP_STOP) |=> done_o && !busy_o);

  // R1: first operation of every transaction is a start
  p_open_start_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> eng_op_o == 3'(OP_START));

  // R6: read index stays inside the block limit
  p_rd_idx_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> rd_idx_o < CW'(MAX_BLK));
endmodule

// File: tb/smb_txn_seq_tb_top.sv
module smb_txn_seq_tb_top;
  logic         clk = 1'b0, rst_n = 1'b0;
  logic         req_i = 1'b0, pec_en = 1'b0;
  logic [3:0]   type_i = '0;
  logic [6:0]   addr_i = '0;
  logic [7:0]   cmd_i = '0;
  logic [5:0]   wcount_i = '0;
  logic [255:0] wdata_v = '0;
  logic         busy_o, done_o, rd_valid_o, eng_valid_o, eng_ack_o;
  logic [1:0]   status_o;
  logic [5:0]   rd_idx_o, count_o;
  logic [7:0]   rd_data_o, eng_wdata_o;
  logic [2:0]   eng_op_o;
  logic         eng_done = 1'b0, eng_nack = 1'b0;
  logic [7:0]   eng_rdata = '0;

  always #5 clk = ~clk;

  smb_txn_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req_i), .type_i(type_i), .addr_i(addr_i),
    .cmd_i(cmd_i), .wcount_i(wcount_i), .wdata_i(wdata_v), .pec_en_i(pec_en),
    .busy_o(busy_o), .done_o(done_o), .status_o(status_o), .rd_valid_o(rd_valid_o),
    .rd_idx_o(rd_idx_o), .rd_data_o(rd_data_o), .count_o(count_o),
    .eng_valid_o(eng_valid_o), .eng_op_o(eng_op_o), .eng_wdata_o(eng_wdata_o),
    .eng_ack_o(eng_ack_o), .eng_done_i(eng_done), .eng_rdata_i(eng_rdata), .eng_nack_i(eng_nack)
  );

  int errs = 0, checks = 0, cyc = 0;
  logic [7:0] wd [32];
  int e_ent [256]; int n_exp = 0;
  int g_ent [256]; int n_log = 0;
  logic [7:0] rsp [80]; int n_rsp = 0, rsp_i = 0;
  logic [7:0] erd [64]; int n_erd = 0;
  logic [7:0] grd [64]; int n_grd = 0;
  int e_stat = 0, wi = 0, m_wi = 0, nack_at = -1;
  logic [7:0] ecrc = '0;
  bit got_done = 0; int g_stat = 0, g_cnt = 0;

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] crcf(logic [7:0] c, logic [7:0] b);
    logic [7:0] r = c ^ b;
    for (int k = 0; k < 8; k++) r = r[7] ? ((r << 1) ^ 8'h07) : (r << 1);
    return r;
  endfunction

  function automatic void push(int op, int by, int ak);
    if (n_exp < 256) e_ent[n_exp] = op * 512 + by * 2 + ak;
    n_exp++;
  endfunction

  function automatic bit wr(logic [7:0] b);
    push(2, int'(b), 0);
    ecrc = crcf(ecrc, b);
    if (wi == nack_at) begin wi++; push(4, 0, 0); e_stat = 1; return 0; end
    wi++;
    return 1;
  endfunction

  function automatic void rd(logic [7:0] b, int ak);
    push(3, int'(b), ak);
    rsp[n_rsp] = b; n_rsp++;
    ecrc = crcf(ecrc, b);
  endfunction

  function automatic void rd_tail(int n, bit blk, int pe, int lim, int rc, int pb);
    logic [7:0] b;
    if (blk) begin
      rd(8'(rc), 1);
      if (rc < 1 || rc > lim) begin push(4, 0, 0); e_stat = 2; return; end
    end
    for (int i = 0; i < n; i++) begin
      b = 8'($urandom);
      rd(b, (i < n - 1 || pe != 0) ? 1 : 0);
      erd[n_erd] = b; n_erd++;
    end
    if (pe != 0) begin
      b = ecrc ^ 8'(pb);
      push(3, int'(b), 0);
      rsp[n_rsp] = b; n_rsp++;
      if (pb != 0) e_stat = 3;
    end
    push(4, 0, 0);
  endfunction

  // expected bus transcript, target replies and result from the requirements
  function automatic void build_exp(int tt, int ad, int cm, int wc, int pe, int rc, int pb);
    int lim, nw, nr;
    logic [7:0] a;
    n_exp = 0; n_rsp = 0; n_erd = 0; e_stat = 0; ecrc = '0; wi = 0;
    lim = (tt == 10) ? 31 : 32;
    if (tt > 10) begin e_stat = 2; return; end
    if ((tt == 8 || tt == 10) && (wc < 1 || wc > lim)) begin e_stat = 2; return; end
    push(0, 0, 0);
    a = (tt == 0) ? {7'(ad), wd[0][0]} : {7'(ad), (tt == 2)};
    if (!wr(a)) return;
    if (tt == 0) begin push(4, 0, 0); return; end
    if (tt == 2) begin rd_tail(1, 0, pe, lim, rc, pb); return; end
    if (tt != 1) if (!wr(8'(cm))) return;
    nw = (tt == 1 || tt == 3) ? 1 : (tt == 5 || tt == 7) ? 2 : (tt == 8 || tt == 10) ? wc : 0;
    if (tt == 8 || tt == 10) if (!wr(8'(wc))) return;
    for (int i = 0; i < nw; i++) if (!wr(wd[i])) return;
    if (tt == 4 || tt == 6 || tt == 7 || tt == 9 || tt == 10) begin
      push(1, 0, 0);
      if (!wr({7'(ad), 1'b1})) return;
      nr = (tt == 4) ? 1 : (tt == 9 || tt == 10) ? rc : 2;
      rd_tail(nr, tt >= 9, pe, lim, rc, pb);
      return;
    end
    if (pe != 0) if (!wr(ecrc)) return;
    push(4, 0, 0);
  endfunction

  // engine and target model plus output monitor, all at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (cyc > 150000) begin
        errs++; checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d cycles", cyc, 150000);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
      end
      if (rd_valid_o) begin grd[rd_idx_o] = rd_data_o; n_grd++; end
      if (done_o) begin got_done = 1; g_stat = int'(status_o); g_cnt = int'(count_o); end
      if (eng_done) begin
        eng_done = 1'b0; eng_nack = 1'b0;
      end else if (eng_valid_o && ($urandom % 4) != 0) begin
        if (n_log < 256) g_ent[n_log] = int'(eng_op_o) * 512 + int'(eng_wdata_o) * 2 +
                                         ((eng_op_o == 3'd3) ? int'(eng_ack_o) : 0);
        if (eng_op_o == 3'd3) g_ent[n_log] = int'(eng_op_o) * 512 +
            ((rsp_i < n_rsp) ? int'(rsp[rsp_i]) : 8'hA5) * 2 + int'(eng_ack_o);
        n_log++;
        eng_nack = (eng_op_o == 3'd2) && (m_wi == nack_at);
        if (eng_op_o == 3'd2) m_wi++;
        if (eng_op_o == 3'd3) begin
          eng_rdata = (rsp_i < n_rsp) ? rsp[rsp_i] : 8'hA5;
          rsp_i++;
        end
        eng_done = 1'b1;
      end
    end
  end

  task automatic run(string tag, int tt, int ad, int cm, int wc, int pe, int na, int rc, int pb, bit poke);
    int to, bad, n_hold;
    for (int i = 0; i < 32; i++) wd[i] = 8'($urandom);
    nack_at = na;
    build_exp(tt, ad, cm, wc, pe, rc, pb);
    @(negedge clk);
    n_log = 0; n_grd = 0; rsp_i = 0; m_wi = 0; got_done = 0;
    req_i = 1'b1; type_i = 4'(tt); addr_i = 7'(ad); cmd_i = 8'(cm);
    wcount_i = 6'(wc); pec_en = (pe != 0);
    for (int i = 0; i < 32; i++) wdata_v[8*i +: 8] = wd[i];
    @(negedge clk); #1;
    req_i = 1'b0;
    if (tt > 10) chk(tag, "done in cycle after request", int'(got_done), 1);
    if (poke) begin
      repeat (3) @(negedge clk);
      req_i = 1'b1; type_i = 4'd0; addr_i = 7'h11;
      @(negedge clk); #1;
      req_i = 1'b0;
    end
    to = 0;
    while (!got_done && to < 6000) begin @(negedge clk); #1; to++; end
    chk(tag, "done seen", int'(got_done), 1);
    chk(tag, "status", g_stat, e_stat);
    bad = -1;
    for (int i = 0; i < n_exp && i < 256; i++) if (bad < 0 && g_ent[i] != e_ent[i]) bad = i;
    if (n_log != n_exp) chk(tag, "bus operation count", n_log, n_exp);
    else if (bad >= 0) chk(tag, $sformatf("bus op %0d (op*512+byte*2+ack)", bad), g_ent[bad], e_ent[bad]);
    else chk(tag, "bus transcript", n_log, n_exp);
    chk(tag, "read bytes delivered", n_grd, n_erd);
    chk(tag, "count_o", g_cnt, n_erd);
    bad = -1;
    for (int i = 0; i < n_erd && i < n_grd; i++) if (bad < 0 && grd[i] != erd[i]) bad = i;
    if (bad >= 0) chk(tag, $sformatf("read byte %0d", bad), int'(grd[bad]), int'(erd[bad]));
    if (poke) begin
      n_hold = n_log;
      repeat (4) @(negedge clk); #1;
      chk(tag, "busy after ignored request", int'(busy_o), 0);
      chk(tag, "no bus traffic after ignored request", n_log, n_hold);
    end
  endtask

  initial begin
    int tt, pe, lim, wc, rc, na, pb;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    #1;
    chk("R13", "reset busy_o", int'(busy_o), 0);
    chk("R13", "reset done_o", int'(done_o), 0);
    chk("R14", "reset eng_valid_o", int'(eng_valid_o), 0);
    chk("R13", "reset status_o", int'(status_o), 0);
    rst_n = 1'b1;

    run("R2",  0, 'h2A, 0,    0, 1, -1, 0, 0, 0);
    run("R8",  1, 'h13, 0,    0, 1, -1, 0, 0, 0);
    run("R5",  2, 'h55, 0,    0, 1, -1, 0, 0, 0);
    run("R1",  3, 'h40, 'h9C, 0, 0, -1, 0, 0, 0);
    run("R3",  4, 'h0B, 'h21, 0, 0, -1, 0, 0, 0);
    run("R4",  5, 'h7F, 'h02, 0, 1, -1, 0, 0, 0);
    run("R4",  6, 'h33, 'hF0, 0, 1, -1, 0, 0, 0);
    run("R4",  7, 'h01, 'h44, 0, 0, -1, 0, 0, 0);
    run("R7",  8, 'h50, 'h10, 32, 1, -1, 0, 0, 0);
    run("R6",  9, 'h50, 'h11, 0, 1, -1, 32, 0, 0);
    run("R6", 10, 'h22, 'h12, 31, 0, -1, 31, 0, 0);
    run("R7",  8, 'h50, 'h10, 0, 0, -1, 0, 0, 0);
    run("R7", 10, 'h50, 'h10, 32, 0, -1, 1, 0, 0);
    run("R11", 9, 'h50, 'h10, 0, 0, -1, 0, 0, 0);
    run("R11", 9, 'h50, 'h10, 0, 1, -1, 33, 0, 0);
    run("R11",10, 'h50, 'h10, 4, 0, -1, 32, 0, 0);
    run("R10", 4, 'h6E, 'h01, 0, 0, 0, 0, 0, 0);
    run("R10", 8, 'h6E, 'h01, 9, 0, 2, 0, 0, 0);
    run("R10", 5, 'h6E, 'h01, 0, 1, 4, 0, 0, 0);
    run("R9",  6, 'h19, 'h07, 0, 1, -1, 0, 1, 0);
    run("R9", 10, 'h19, 'h07, 3, 1, -1, 5, 8, 0);
    run("R12", 13, 'h19, 'h07, 0, 0, -1, 0, 0, 0);
    run("R13", 8, 'h3C, 'h70, 30, 0, -1, 0, 0, 1);

    for (int n = 0; n < 150; n++) begin
      tt  = $urandom % 11;
      pe  = $urandom % 2;
      lim = (tt == 10) ? 31 : 32;
      wc  = 1 + $urandom % lim;
      rc  = 1 + $urandom % lim;
      na  = (($urandom % 8) == 0) ? int'($urandom % 5) : -1;
      if (($urandom % 12) == 0) rc = (($urandom % 2) == 0) ? 0 : 40;
      pb  = (pe != 0 && ($urandom % 6) == 0) ? 1 + int'($urandom % 255) : 0;
      run("R1/R14", tt, int'($urandom % 128), int'($urandom % 256), wc, pe, na, rc, pb, 0);
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule